// File: doc/BRIEF.md
# Packed 16-bit Integer ALU

This block is a registered integer unit for a single vector lane. Each cycle it can accept one operation: a 6-bit opcode, two 32-bit source words and a valid strobe. Every operation reads only the low half of each source and writes a 16-bit result. The result appears one clock later in a 32-bit destination register whose upper half is always zero.

The supported operations are add, subtract, reverse subtract, low-half multiply, the three shifts, and unsigned and signed minimum. The shifts use reversed operand order: the first source gives the shift distance and the second source is the value that is shifted. Any opcode outside the supported set does not write a result. The lane sees an illegal flag in the same cycle that the valid result would have appeared, and the destination keeps its previous value.

Top module: `pk16_alu`

## Requirements
- R1: Opcode 0x26 returns the low 16 bits of src_a plus src_b. The carry is discarded.
- R2: Opcode 0x27 returns src_a minus src_b, wrapped modulo 65536.
- R3: Opcode 0x28 returns src_b minus src_a, wrapped modulo 65536.
- R4: Opcode 0x29 returns the low 16 bits of the product of the two low halves.
- R5: Opcode 0x2a shifts src_b[15:0] left and opcode 0x2b shifts it right logically. The distance is src_a[3:0], with zero fill. Bits src_a[31:4] have no effect.
- R6: Opcode 0x2c shifts src_b[15:0] right arithmetically by src_a[3:0], replicating bit 15.
- R7: Opcode 0x31 returns the smaller low half compared as unsigned. Opcode 0x32 returns the smaller one compared as signed two's complement.
- R8: Bits 31:16 of either source never affect a result, and out_data[31:16] is always zero.
- R9: A valid strobe with any other opcode raises out_illegal one cycle later, together with out_valid, and leaves out_data unchanged.
- R10: out_valid equals the in_valid of the previous cycle. A legal valid operation updates out_data at that same edge. While rst_n is low at a clock edge, out_valid, out_illegal and out_data clear to zero.
- R11: A cycle with in_valid low leaves out_data unchanged and gives out_illegal low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 6 | Short-form operation code |
| src_a | input | 32 | First source; gives the shift distance for shifts |
| src_b | input | 32 | Second source; the shifted value for shifts |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_illegal | output | 1 | Unsupported opcode seen on the previous strobe |
| out_data | output | 32 | Destination register, upper half zero |

## Verification
The hardest cases to reach from the ports are the ones where something must have no effect. Junk in src_a[31:4] must not change a shift, and an illegal opcode must leave behind a nonzero destination value that it did not overwrite. The stimulus sweeps all 64 opcodes back to back with edge operands that carry random upper bits, so every illegal code follows a legal result the bench already knows. A separate sweep runs every 5-bit shift distance against sign-bit patterns, which separates the arithmetic right shift from the logical one. Signed and unsigned minimum are both driven with operands across the 0x7fff/0x8000 boundary, where the two comparisons give different answers.

// File: rtl/pk16_pkg.sv
package pk16_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_ADD  = 6'h26;
   localparam logic [OPC_W-1:0] OPC_SUB  = 6'h27;
   localparam logic [OPC_W-1:0] OPC_RSUB = 6'h28;
   localparam logic [OPC_W-1:0] OPC_MUL  = 6'h29;
   localparam logic [OPC_W-1:0] OPC_SHL  = 6'h2a;
   localparam logic [OPC_W-1:0] OPC_SHR  = 6'h2b;
   localparam logic [OPC_W-1:0] OPC_SRA  = 6'h2c;
   localparam logic [OPC_W-1:0] OPC_MINU = 6'h31;
   localparam logic [OPC_W-1:0] OPC_MINS = 6'h32;

   typedef enum logic [3:0] {
      K_NONE,
      K_ADD,
      K_SUB,
      K_RSUB,
      K_MUL,
      K_SHL,
      K_SHR,
      K_SRA,
      K_MINU,
      K_MINS
   } op_kind_e;

endpackage

// File: rtl/pk16_decode.sv
module pk16_decode
   import pk16_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output op_kind_e         kind,
   output logic             legal
);

   always_comb begin
      case (opcode)
         OPC_ADD:  kind = K_ADD;
         OPC_SUB:  kind = K_SUB;
         OPC_RSUB: kind = K_RSUB;
         OPC_MUL:  kind = K_MUL;
         OPC_SHL:  kind = K_SHL;
         OPC_SHR:  kind = K_SHR;
         OPC_SRA:  kind = K_SRA;
         OPC_MINU: kind = K_MINU;
         OPC_MINS: kind = K_MINS;
         default:  kind = K_NONE;
      endcase
   end

   assign legal = (kind != K_NONE);

endmodule

// File: rtl/pk16_arith.sv
module pk16_arith
   import pk16_pkg::*;
#(
   parameter int W        = 16,
   parameter bit MUL_ITER = 1'b0
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  op_kind_e     kind,
   output logic [W-1:0] res
);

   logic [W-1:0] prod;

   generate
      if (MUL_ITER) begin : g_mul_shift_add
         logic [W-1:0] acc [0:W];
         assign acc[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_pp
            assign acc[i+1] = acc[i] + (b[i] ? (a << i) : {W{1'b0}});
         end
         assign prod = acc[W];
      end else begin : g_mul_native
         assign prod = W'(a * b);
      end
   endgenerate

   always_comb begin
      case (kind)
         K_ADD:   res = a + b;
         K_SUB:   res = a - b;
         K_RSUB:  res = b - a;
         K_MUL:   res = prod;
         default: res = '0;
      endcase
   end

   always_comb begin
      if (kind == K_ADD) begin
         assert_add_inverse_R1: assert (W'(res - b) == a);
      end
      if (kind == K_SUB) begin
         assert_sub_inverse_R2: assert (W'(res + b) == a);
      end
      if (kind == K_RSUB) begin
         assert_rsub_inverse_R3: assert (W'(res + a) == b);
      end
      if (kind == K_MUL && b == W'(1)) begin
         assert_mul_identity_R4: assert (res == a);
      end
   end

endmodule

// File: rtl/pk16_shift.sv
module pk16_shift #(
   parameter int W      = 16,
   parameter bit BARREL = 1'b1,
   localparam int SH_W  = $clog2(W)
)(
   input  logic [W-1:0]    b,
   input  logic [SH_W-1:0] amt,
   input  logic            left,
   input  logic            arith,
   input  logic            active,
   output logic [W-1:0]    res
);

   generate
      if (BARREL) begin : g_log_stages
         function automatic logic [W-1:0] flip(input logic [W-1:0] v);
            logic [W-1:0] r;
            for (int i = 0; i < W; i++) r[i] = v[W-1-i];
            return r;
         endfunction

         logic          fill;
         logic [W-1:0]  stage [0:SH_W];

         assign fill     = arith & ~left & b[W-1];
         assign stage[0] = left ? flip(b) : b;

         for (genvar s = 0; s < SH_W; s++) begin : g_stage
            localparam int D = 1 << s;
            assign stage[s+1] = amt[s] ? {{D{fill}}, stage[s][W-1:D]} : stage[s];
         end

         assign res = left ? flip(stage[SH_W]) : stage[SH_W];
      end else begin : g_behavioural
         always_comb begin
            if (left)       res = b << amt;
            else if (arith) res = W'($signed(b) >>> amt);
            else            res = b >> amt;
         end
      end
   endgenerate

   always_comb begin
      if (active && amt == '0) begin
         assert_shift_zero_R5: assert (res == b);
      end
      if (active && arith && !left) begin
         assert_sra_sign_R6: assert (res[W-1] == b[W-1]);
      end
   end

endmodule

// File: rtl/pk16_min.sv
module pk16_min #(
   parameter int W = 16
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         signed_cmp,
   input  logic         active,
   output logic [W-1:0] res
);

   logic [W-1:0] bias;
   logic         a_lt;

   assign bias = signed_cmp ? {1'b1, {(W-1){1'b0}}} : '0;
   assign a_lt = (a ^ bias) < (b ^ bias);
   assign res  = a_lt ? a : b;

   always_comb begin
      if (active) begin
         assert_min_pick_R7: assert (res == a || res == b);
         assert_min_le_R7:   assert ((res ^ bias) <= (a ^ bias) && (res ^ bias) <= (b ^ bias));
      end
   end

endmodule

// File: rtl/pk16_alu.sv
module pk16_alu
   import pk16_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int SRC_W     = 32,
   parameter bit MUL_ITER  = 1'b0,
   parameter bit SH_BARREL = 1'b1,
   localparam int SH_W     = $clog2(DATA_W)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [SRC_W-1:0]  src_a,
   input  logic [SRC_W-1:0]  src_b,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [SRC_W-1:0]  out_data
);

   generate
      if (SRC_W < DATA_W) begin : g_chk_src_w
         $error("pk16_alu: SRC_W must be at least DATA_W");
      end
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_data_w
         $error("pk16_alu: DATA_W must be a power of two of at least 2");
      end
   endgenerate

   op_kind_e          kind;
   logic              legal;
   logic [DATA_W-1:0] lo_a;
   logic [DATA_W-1:0] lo_b;
   logic [DATA_W-1:0] arith_res;
   logic [DATA_W-1:0] shift_res;
   logic [DATA_W-1:0] min_res;
   logic [DATA_W-1:0] sel_res;
   logic              is_shift;
   logic              is_min;

   logic              valid_q;
   logic              illegal_q;
   logic [SRC_W-1:0]  data_q;

   assign lo_a = src_a[DATA_W-1:0];
   assign lo_b = src_b[DATA_W-1:0];

   pk16_decode u_decode (
      .opcode (opcode),
      .kind   (kind),
      .legal  (legal)
   );

   pk16_arith #(
      .W        (DATA_W),
      .MUL_ITER (MUL_ITER)
   ) u_arith (
      .a    (lo_a),
      .b    (lo_b),
      .kind (kind),
      .res  (arith_res)
   );

   assign is_shift = (kind == K_SHL) || (kind == K_SHR) || (kind == K_SRA);
   assign is_min   = (kind == K_MINU) || (kind == K_MINS);

   pk16_shift #(
      .W      (DATA_W),
      .BARREL (SH_BARREL)
   ) u_shift (
      .b      (lo_b),
      .amt    (src_a[SH_W-1:0]),
      .left   (kind == K_SHL),
      .arith  (kind == K_SRA),
      .active (is_shift),
      .res    (shift_res)
   );

   pk16_min #(
      .W (DATA_W)
   ) u_min (
      .a          (lo_a),
      .b          (lo_b),
      .signed_cmp (kind == K_MINS),
      .active     (is_min),
      .res        (min_res)
   );

   always_comb begin
      if (is_shift)    sel_res = shift_res;
      else if (is_min) sel_res = min_res;
      else             sel_res = arith_res;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         illegal_q <= 1'b0;
         data_q    <= '0;
      end else begin
         valid_q   <= in_valid;
         illegal_q <= in_valid & ~legal;
         if (in_valid && legal) begin
            data_q <= SRC_W'(sel_res);
         end
      end
   end

   assign out_valid   = valid_q;
   assign out_illegal = illegal_q;
   assign out_data    = data_q;

   always_comb begin
      if (rst_n && in_valid) begin
         assert_src_known_R8: assert (!$isunknown({src_a, src_b, opcode}));
      end
   end

   assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_data >> DATA_W) == '0);

   assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_illegal && $stable(out_data)));

   assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !legal) |=> (out_valid && out_illegal));

   assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> $stable(out_data));

   assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> out_valid);

endmodule

// File: tb/pk16_alu_tb.sv
module pk16_alu_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [5:0]  opcode;
   logic [31:0] src_a;
   logic [31:0] src_b;
   logic        out_valid;
   logic        out_illegal;
   logic [31:0] out_data;

   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;
   logic [31:0] exp_data;
   logic [31:0] lfsr = 32'hACE1_2468;

   always #(CLK_PERIOD/2) clk = ~clk;

   pk16_alu dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .opcode      (opcode),
      .src_a       (src_a),
      .src_b       (src_b),
      .out_valid   (out_valid),
      .out_illegal (out_illegal),
      .out_data    (out_data)
   );

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   function automatic bit is_legal(input logic [5:0] op);
      return (op >= 6'h26 && op <= 6'h2c) || op == 6'h31 || op == 6'h32;
   endfunction

   function automatic logic [15:0] model(input logic [5:0] op, input logic [15:0] a,
                                         input logic [15:0] b);
      int unsigned ua = a;
      int unsigned ub = b;
      int sa = $signed(a);
      int sb = $signed(b);
      int unsigned n = a[3:0];
      case (op)
         6'h26: return 16'((ua + ub) % 65536);
         6'h27: return 16'((ua + 65536 - ub) % 65536);
         6'h28: return 16'((ub + 65536 - ua) % 65536);
         6'h29: return 16'((ua * ub) % 65536);
         6'h2a: return 16'((ub * (1 << n)) % 65536);
         6'h2b: return 16'(ub / (1 << n));
         6'h2c: return 16'(sb >>> n);
         6'h31: return (ua < ub) ? a : b;
         6'h32: return (sa < sb) ? a : b;
         default: return 16'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [5:0] op);
      case (op)
         6'h26: return "R1";
         6'h27: return "R2";
         6'h28: return "R3";
         6'h29: return "R4";
         6'h2a, 6'h2b: return "R5";
         6'h2c: return "R6";
         6'h31, 6'h32: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input bit v, input logic [5:0] op, input logic [31:0] a,
                        input logic [31:0] b);
      @(negedge clk);
      in_valid = v;
      opcode   = op;
      src_a    = a;
      src_b    = b;
      @(posedge clk);
      #1;
      if (v && is_legal(op)) exp_data = {16'h0, model(op, a[15:0], b[15:0])};
      check(out_valid == v, "R10", {31'h0, out_valid}, {31'h0, v});
      check(out_illegal == (v && !is_legal(op)), "R9", {31'h0, out_illegal},
            {31'h0, v && !is_legal(op)});
      if (!v)
         check(out_data == exp_data, "R11", out_data, exp_data);
      else
         check(out_data == exp_data, req_of(op), out_data, exp_data);
      check(out_data[31:16] == 16'h0, "R8", out_data, exp_data);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b1;
      opcode   = 6'h26;
      src_a    = 32'hFFFF_1234;
      src_b    = 32'hFFFF_4321;
      @(posedge clk);
      #1;
      exp_data = 32'h0;
      check(out_valid == 1'b0, "R10", {31'h0, out_valid}, 32'h0);
      check(out_illegal == 1'b0, "R10", {31'h0, out_illegal}, 32'h0);
      check(out_data == 32'h0, "R10", out_data, 32'h0);
      @(negedge clk);
      rst_n    = 1'b1;
      in_valid = 1'b0;
   endtask

   logic [15:0] edges [0:5];

   initial begin
      edges[0] = 16'h0000; edges[1] = 16'h0001; edges[2] = 16'h7FFF;
      edges[3] = 16'h8000; edges[4] = 16'hFFFF; edges[5] = 16'h1234;
      rst_n = 1'b0; in_valid = 1'b0; opcode = '0; src_a = '0; src_b = '0;
      exp_data = 32'h0;
      repeat (2) @(posedge clk);
      do_reset();

      // Full opcode sweep against edge operands with junk in the upper halves (R8, R9)
      for (int op = 0; op < 64; op++) begin
         for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
               lfsr = next_rand(lfsr);
               issue(1'b1, 6'(op), {lfsr[31:16], edges[i]}, {lfsr[15:0], edges[j]});
            end
         end
      end

      // Every 5-bit shift distance: bit 4 and above must be ignored (R5, R6)
      for (int op = 6'h2a; op <= 6'h2c; op++) begin
         for (int n = 0; n < 32; n++) begin
            for (int j = 0; j < 6; j++) begin
               lfsr = next_rand(lfsr);
               issue(1'b1, 6'(op), {lfsr[31:5], 5'(n)}, {lfsr[15:0], edges[j]});
            end
         end
      end

      // Legal result, then an illegal code must keep it (R9)
      issue(1'b1, 6'h29, 32'h0000_00FF, 32'h0000_0101);
      issue(1'b1, 6'h3F, 32'h1111_2222, 32'h3333_4444);
      check(out_data == 32'h0000_FFFF, "R9", out_data, 32'h0000_FFFF);

      // Random mix with idle cycles (R11)
      for (int k = 0; k < 3000; k++) begin
         lfsr = next_rand(lfsr);
         issue(lfsr[3:0] != 4'h0, (lfsr[4] ? 6'h26 + 6'(lfsr[7:5]) : lfsr[10:5]),
               next_rand(lfsr), lfsr);
      end

      // Reset in the middle of traffic clears everything (R10)
      issue(1'b1, 6'h26, 32'h0, 32'h0000_0055);
      do_reset();
      issue(1'b0, 6'h00, 32'h0, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule